// File: doc/BRIEF.md
# Serial Port FIFO Interrupt and Status Controller

This block sits beside the transmit and receive FIFOs of a synchronous serial port. It combines their occupancy counts, an overrun event, a receive-idle timer and the shifter's busy signal into four interrupt sources. Each source has a raw view and a masked view. Two of the sources are latched events that software clears by writing ones. The other two are live level conditions. The block also drives one combined interrupt line, the FIFO status flags, and the transmit and receive DMA requests, each gated by its own enable.

Software reaches the block through a simple register port: a one-cycle write strobe with an address and data, and a combinational read path selected by a separate read address. The FIFOs and the shifter are outside the block. It receives a count from each FIFO, a one-cycle overrun pulse, a pulse for each newly received frame, and a strobe once per serial bit period.

Top module: `sport_irq_status`

## Requirements
- R1: The interrupt source bits are: bit 0 transmit half empty, bit 1 receive half full, bit 2 receive timeout, bit 3 receive overrun. Reading address 1 returns these raw bits whatever the mask holds. Upper read bits are zero.
- R2: Address 0 is a read/write mask with one bit per source. It resets to 0. Reading address 2 returns the raw bits ANDed with the mask.
- R3: Bit 0 is 1 while the transmit count is at most DEPTH/2. Bit 1 is 1 while the receive count is at least DEPTH/2. Writing the clear register never changes either bit.
- R4: Writing to address 3 clears each latched bit (2 and 3) whose data bit is 1. The change shows from the next cycle. Data bits that are 0 leave their latched bit unchanged.
- R5: An overrun pulse sets bit 3 from the next cycle, and bit 3 stays set until it is cleared. When an overrun pulse and a clear of bit 3 fall in the same cycle, bit 3 ends up set.
- R6: Address 4 reads the status flags: bit 0 transmit FIFO empty, bit 1 transmit FIFO not full, bit 2 receive FIFO not empty, bit 3 receive FIFO full, bit 4 shifter busy. These flags also appear on dedicated output ports.
- R7: Bit 2 sets after TIMEOUT_BITS bit-period strobes (default 32) pass while the receive FIFO is non-empty and no frame arrives. A frame pulse or an empty receive FIFO restarts the count. The bit fires at most once per idle span.
- R8: The interrupt output is 1 exactly when at least one bit of raw AND mask is 1.
- R9: Address 5 holds the DMA enables: bit 0 transmit, bit 1 receive. Both reset to 0. The transmit request is enable AND (transmit count at most DEPTH/2). The receive request is enable AND (receive count not zero).
- R10: After reset, the mask, the latched bits and both DMA enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | CW | Transmit FIFO occupancy, 0..DEPTH |
| rx_level | input | CW | Receive FIFO occupancy, 0..DEPTH |
| rx_ovr_pulse | input | 1 | One-cycle receive overrun event |
| rx_frame_pulse | input | 1 | One-cycle pulse per frame received |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| shifter_busy | input | 1 | Serial shifter is active |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Combined interrupt line |
| st_tx_empty | output | 1 | Transmit FIFO empty |
| st_tx_not_full | output | 1 | Transmit FIFO not full |
| st_rx_not_empty | output | 1 | Receive FIFO not empty |
| st_rx_full | output | 1 | Receive FIFO full |
| st_busy | output | 1 | Shifter busy |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
A latched overrun can set in the same cycle that software writes the clear register for that bit, and a timeout can likewise meet a clear. The bench drives this collision on purpose: it raises the overrun pulse in the same cycle as a clear write of bit 3, and then checks in the next cycle that the raw bit is still 1. The random phase also creates many chance collisions of overrun pulses with random clear writes. A bench model decides each outcome, with set taking priority over clear, and a clear with no event must leave the bit at 0.

// File: rtl/sport_irq_pkg.sv
// Shared definitions for the serial port interrupt/status controller.
// Assumes a 3-bit register address space; unused addresses read as zero.
package sport_irq_pkg;
    localparam int NUM_SRC    = 4;
    localparam int SRC_TXHALF = 0;
    localparam int SRC_RXHALF = 1;
    localparam int SRC_RXTO   = 2;
    localparam int SRC_RXOVR  = 3;
    localparam int NUM_STICKY = 2;
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MASK = 3'd0,
        ADDR_RAW  = 3'd1,
        ADDR_MSKD = 3'd2,
        ADDR_CLR  = 3'd3,
        ADDR_STAT = 3'd4,
        ADDR_DMA  = 3'd5
    } reg_addr_e;

    // Packed so that tx_empty is bit 0 and busy is bit 4.
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_not_empty;
        logic tx_not_full;
        logic tx_empty;
    } fifo_status_t;

    localparam int STAT_W = $bits(fifo_status_t);
endpackage

// File: rtl/fifo_level_flags.sv
// Derives FIFO status flags and the two half-level interrupt conditions
// from occupancy counts. Assumes counts never exceed DEPTH. Purely combinational.
module fifo_level_flags
    import sport_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic          shifter_busy,
    output fifo_status_t  status,
    output logic          tx_half,
    output logic          rx_half
);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // Occupancy comparisons for flags and thresholds.
    always_comb begin
        status.tx_empty     = (tx_level == '0);
        status.tx_not_full  = (tx_level < FULL);
        status.rx_not_empty = (rx_level != '0);
        status.rx_full      = (rx_level >= FULL);
        status.busy         = shifter_busy;
        tx_half             = (tx_level <= HALF);
        rx_half             = (rx_level >= HALF);
    end
endmodule

// File: rtl/rx_idle_timer.sv
// Counts bit-period strobes while the receive FIFO holds data and no frame
// arrives. Emits a one-cycle event on the strobe that completes TIMEOUT_BITS.
// After firing it stays quiet until a frame arrives or the FIFO empties.
module rx_idle_timer #(
    parameter int TIMEOUT_BITS = 32,
    parameter int TW           = $clog2(TIMEOUT_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_pulse,
    input  logic rx_not_empty,
    output logic timeout_evt
);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_BITS - 1);

    logic [TW-1:0] cnt_q;
    logic          armed_q;
    logic          restart;

    // Restart condition: new frame or nothing left to time out on.
    assign restart     = frame_pulse || !rx_not_empty;
    // The event fires on the strobe that reaches the limit.
    assign timeout_evt = armed_q && !restart && bit_tick && (cnt_q == LAST);

    // Idle counter with one-shot arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (restart) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (bit_tick && armed_q) begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sticky_event_bits.sv
// A bank of latched event bits. Set has priority over a write-one clear
// in the same cycle. Assumes set_vec bits are single-cycle pulses.
module sticky_event_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One latched bit: set wins, otherwise clear on write-one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_vec[i])
                q[i] <= 1'b1;
            else if (clr_wr && clr_vec[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_host_regs.sv
// Host-visible registers: interrupt mask, DMA enables, clear decode and
// the combinational read mux. Assumes DATA_W is at least STAT_W.
module irq_host_regs
    import sport_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SRC-1:0]  raw_vec,
    input  fifo_status_t        status,
    output logic [NUM_SRC-1:0]  mask_q,
    output logic                dma_tx_en_q,
    output logic                dma_rx_en_q,
    output logic                clr_wr,
    output logic [NUM_SRC-1:0]  clr_bits,
    output logic [DATA_W-1:0]   rd_data
);
    logic unused_hi;

    // Upper write bits carry no meaning in any register.
    assign unused_hi = ^wr_data[DATA_W-1:NUM_SRC];

    // Clear register decode, passed on to the latched bits.
    assign clr_wr   = wr_en && (wr_addr == ADDR_CLR);
    assign clr_bits = wr_data[NUM_SRC-1:0];

    // Mask and DMA enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '0;
            dma_tx_en_q <= 1'b0;
            dma_rx_en_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_MASK)
                mask_q <= wr_data[NUM_SRC-1:0];
            if (wr_addr == ADDR_DMA) begin
                dma_tx_en_q <= wr_data[0];
                dma_rx_en_q <= wr_data[1];
            end
        end
    end

    // Read mux; the clear register and unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_MASK: rd_data = DATA_W'(mask_q);
            ADDR_RAW:  rd_data = DATA_W'(raw_vec);
            ADDR_MSKD: rd_data = DATA_W'(raw_vec & mask_q);
            ADDR_STAT: rd_data = DATA_W'(status);
            ADDR_DMA:  rd_data = DATA_W'({dma_rx_en_q, dma_tx_en_q});
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sport_irq_status.sv
// Top of the serial port interrupt/status controller. It joins the level
// flags, the idle timer, the latched event bits and the host registers,
// and it drives the interrupt line and the DMA requests.
// Assumes the FIFO counts are synchronous to clk and bounded by DEPTH.
module sport_irq_status
    import sport_irq_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int TIMEOUT_BITS = 32,
    parameter int DATA_W       = 8,
    parameter int CW           = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     tx_level,
    input  logic [CW-1:0]     rx_level,
    input  logic              rx_ovr_pulse,
    input  logic              rx_frame_pulse,
    input  logic              bit_tick,
    input  logic              shifter_busy,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              st_tx_empty,
    output logic              st_tx_not_full,
    output logic              st_rx_not_empty,
    output logic              st_rx_full,
    output logic              st_busy,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    fifo_status_t            status;
    logic                    tx_half;
    logic                    rx_half;
    logic                    timeout_evt;
    logic [NUM_STICKY-1:0]   sticky_q;
    logic [NUM_SRC-1:0]      raw_vec;
    logic [NUM_SRC-1:0]      mask_q;
    logic                    dma_tx_en_q;
    logic                    dma_rx_en_q;
    logic                    clr_wr;
    logic [NUM_SRC-1:0]      clr_bits;

    fifo_level_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .shifter_busy (shifter_busy),
        .status       (status),
        .tx_half      (tx_half),
        .rx_half      (rx_half)
    );

    rx_idle_timer #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .frame_pulse  (rx_frame_pulse),
        .rx_not_empty (status.rx_not_empty),
        .timeout_evt  (timeout_evt)
    );

    // Latched bit 0 is the timeout, bit 1 is the overrun.
    sticky_event_bits #(.N(NUM_STICKY)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec ({rx_ovr_pulse, timeout_evt}),
        .clr_wr  (clr_wr),
        .clr_vec (clr_bits[SRC_RXOVR:SRC_RXTO]),
        .q       (sticky_q)
    );

    irq_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .raw_vec     (raw_vec),
        .status      (status),
        .mask_q      (mask_q),
        .dma_tx_en_q (dma_tx_en_q),
        .dma_rx_en_q (dma_rx_en_q),
        .clr_wr      (clr_wr),
        .clr_bits    (clr_bits),
        .rd_data     (rd_data)
    );

    // Raw vector assembly in source-bit order.
    assign raw_vec = {sticky_q[1], sticky_q[0], rx_half, tx_half};

    // Combined interrupt and DMA requests.
    assign irq        = |(raw_vec & mask_q);
    assign dma_tx_req = dma_tx_en_q && tx_half;
    assign dma_rx_req = dma_rx_en_q && status.rx_not_empty;

    // Status flags brought out on dedicated pins.
    assign st_tx_empty     = status.tx_empty;
    assign st_tx_not_full  = status.tx_not_full;
    assign st_rx_not_empty = status.rx_not_empty;
    assign st_rx_full      = status.rx_full;
    assign st_busy         = status.busy;
endmodule

// File: rtl/sport_irq_checker.sv
// Protocol checks on the interrupt/status controller, bound to the top.
module sport_irq_checker #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [3:0]    wr_lo,
    input logic          rx_ovr_pulse,
    input logic [CW-1:0] rx_level,
    input logic [3:0]    raw_vec,
    input logic [3:0]    mask_q,
    input logic          irq,
    input logic          dma_rx_req,
    input logic          st_tx_empty,
    input logic          st_tx_not_full
);
    logic clr3;
    assign clr3 = wr_en && (wr_addr == 3'd3) && wr_lo[3];

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr_pulse |=> raw_vec[3]); // R5
    AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec[3] && !clr3) |=> raw_vec[3]); // R5
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr3 && !rx_ovr_pulse) |=> !raw_vec[3]); // R4
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'd0) |-> !irq); // R8
    AST_RX_DMA_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> (rx_level != '0)); // R9
    AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_tx_empty |-> st_tx_not_full); // R6
endmodule

bind sport_irq_status sport_irq_checker #(.CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_lo          (wr_data[3:0]),
    .rx_ovr_pulse   (rx_ovr_pulse),
    .rx_level       (rx_level),
    .raw_vec        (raw_vec),
    .mask_q         (mask_q),
    .irq            (irq),
    .dma_rx_req     (dma_rx_req),
    .st_tx_empty    (st_tx_empty),
    .st_tx_not_full (st_tx_not_full)
);

// File: tb/test_sport_irq_status.sv
module test_sport_irq_status;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int CW     = 4;
    localparam int TOB    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] tx_level = '0, rx_level = '0;
    logic rx_ovr_pulse = 1'b0, rx_frame_pulse = 1'b0, bit_tick = 1'b0, shifter_busy = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic irq, st_tx_empty, st_tx_not_full, st_rx_not_empty, st_rx_full, st_busy;
    logic dma_tx_req, dma_rx_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench model state
    logic [3:0] m_mask;
    logic [1:0] m_st;   // [0] timeout, [1] overrun
    logic [1:0] m_dma;

    always #(PERIOD/2) clk = ~clk;

    sport_irq_status #(.DEPTH(DEPTH), .TIMEOUT_BITS(TOB), .DATA_W(8)) i_sport_irq_status (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .rx_ovr_pulse(rx_ovr_pulse), .rx_frame_pulse(rx_frame_pulse), .bit_tick(bit_tick),
        .shifter_busy(shifter_busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .st_tx_empty(st_tx_empty),
        .st_tx_not_full(st_tx_not_full), .st_rx_not_empty(st_rx_not_empty),
        .st_rx_full(st_rx_full), .st_busy(st_busy), .dma_tx_req(dma_tx_req),
        .dma_rx_req(dma_rx_req));

    function automatic logic [7:0] f_raw(logic [CW-1:0] t, logic [CW-1:0] r, logic [1:0] s);
        return {4'd0, s[1], s[0], (r >= CW'(DEPTH/2)), (t <= CW'(DEPTH/2))};
    endfunction

    function automatic logic [7:0] f_stat(logic [CW-1:0] t, logic [CW-1:0] r, logic b);
        return {3'd0, b, (r == CW'(DEPTH)), (r != 0), (t != CW'(DEPTH)), (t == 0)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(3'd0, d); chk("R10 mask reset", d, 8'h00);
        rd(3'd1, d); chk("R10 raw reset", d, f_raw(0, 0, 2'b00));
        rd(3'd5, d); chk("R10 dma enables reset", d, 8'h00);
        chk("R10 irq reset", irq, 1'b0);
        chk("R9 no dma after reset", {dma_tx_req, dma_rx_req}, 2'b00);

        // Level bits and clear has no effect on them
        tx_level = 4'd4; rx_level = 4'd4;
        wr(3'd3, 8'h0F);
        rd(3'd1, d); chk("R3 clear ignores level bits", d, 8'h03);
        tx_level = 4'd5; rx_level = 4'd3;
        rd(3'd1, d); chk("R3 levels beyond half", d, 8'h00);
        rd(3'd6, d); chk("R1 unmapped read zero", d, 8'h00);

        // Mask and masked view, irq
        tx_level = 4'd0;
        wr(3'd0, 8'hF2);
        rd(3'd0, d); chk("R2 mask readback", d, 8'h02);
        rd(3'd2, d); chk("R2 masked view", d, 8'h00);
        chk("R8 irq off when masked source off", irq, 1'b0);
        rx_level = 4'd6; #1;
        rd(3'd2, d); chk("R2 masked view rx half", d, 8'h02);
        chk("R8 irq on", irq, 1'b1);

        // Overrun sticky, set beats clear
        @(negedge clk);
        rx_ovr_pulse = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h08;
        @(negedge clk);
        rx_ovr_pulse = 1'b0; wr_en = 1'b0;
        rd(3'd1, d); chk("R5 set beats clear", d[3], 1'b1);
        repeat (3) @(negedge clk);
        rd(3'd1, d); chk("R5 overrun stays set", d[3], 1'b1);
        wr(3'd3, 8'h04);
        rd(3'd1, d); chk("R4 zero bit leaves overrun", d[3], 1'b1);
        wr(3'd3, 8'h08);
        rd(3'd1, d); chk("R4 clear overrun", d[3], 1'b0);

        // Timeout
        rx_level = 4'd0; @(negedge clk);
        rx_level = 4'd3;
        ticks(TOB - 1);
        rd(3'd1, d); chk("R7 no timeout one bit early", d[2], 1'b0);
        ticks(1);
        rd(3'd1, d); chk("R7 timeout after full span", d[2], 1'b1);
        ticks(TOB + 2);
        wr(3'd3, 8'h04);
        rd(3'd1, d); chk("R7 fires once per idle span", d[2], 1'b0);
        rx_frame_pulse = 1'b1; @(negedge clk); rx_frame_pulse = 1'b0;
        ticks(20);
        rx_frame_pulse = 1'b1; bit_tick = 1'b1; @(negedge clk);
        rx_frame_pulse = 1'b0;
        ticks(TOB - 1);
        rd(3'd1, d); chk("R7 frame restarts count", d[2], 1'b0);
        ticks(1);
        rd(3'd1, d); chk("R7 timeout after restart", d[2], 1'b1);
        rx_level = 4'd0;
        ticks(TOB + 1);
        wr(3'd3, 8'h04);
        rd(3'd1, d); chk("R7 empty fifo never times out", d[2], 1'b0);

        // DMA
        wr(3'd5, 8'h03);
        tx_level = 4'd4; rx_level = 4'd0; #1;
        chk("R9 tx dma at half", dma_tx_req, 1'b1);
        chk("R9 rx dma empty", dma_rx_req, 1'b0);
        tx_level = 4'd5; rx_level = 4'd1; #1;
        chk("R9 tx dma above half", dma_tx_req, 1'b0);
        chk("R9 rx dma one entry", dma_rx_req, 1'b1);

        // Status flags
        tx_level = 4'd8; rx_level = 4'd8; shifter_busy = 1'b1;
        rd(3'd4, d); chk("R6 status full busy", d, f_stat(8, 8, 1'b1));
        chk("R6 status pins", {st_busy, st_rx_full, st_rx_not_empty, st_tx_not_full, st_tx_empty}, 5'b11100);

        // Random phase from a known state
        wr(3'd0, 8'h00); wr(3'd5, 8'h00); wr(3'd3, 8'h0F);
        m_mask = 4'h0; m_dma = 2'b00; m_st = 2'b00;
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [1:0] nst;
            @(negedge clk);
            tx_level = CW'($urandom % (DEPTH + 1));
            rx_level = CW'($urandom % (DEPTH + 1));
            shifter_busy = 1'($urandom);
            rx_ovr_pulse = (($urandom % 4) == 0);
            op = int'($urandom % 4);
            wr_data = 8'($urandom);
            wr_en = (op != 0);
            wr_addr = (op == 1) ? 3'd0 : (op == 2) ? 3'd3 : 3'd5;
            rd(3'd1, d); chk("R1 random raw", d, f_raw(tx_level, rx_level, m_st));
            rd(3'd2, d); chk("R2 random masked", d, f_raw(tx_level, rx_level, m_st) & {4'd0, m_mask});
            rd(3'd4, d); chk("R6 random status", d, f_stat(tx_level, rx_level, shifter_busy));
            chk("R8 random irq", irq, |(f_raw(tx_level, rx_level, m_st) & {4'd0, m_mask}));
            chk("R9 random dma", {dma_rx_req, dma_tx_req},
                {m_dma[1] && (rx_level != 0), m_dma[0] && (tx_level <= CW'(DEPTH/2))});
            nst[0] = m_st[0] & ~((op == 2) && wr_data[2]);
            nst[1] = rx_ovr_pulse | (m_st[1] & ~((op == 2) && wr_data[3]));
            m_st = nst;
            if (op == 1) m_mask = wr_data[3:0];
            if (op == 3) m_dma = wr_data[1:0];
        end
        @(negedge clk);
        wr_en = 1'b0; rx_ovr_pulse = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule